// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into the base of a 4 KiB physical page. It reads a radix page table with three levels from memory through a simple request/acknowledge port, one entry per access. The requester supplies the virtual address, the privilege of the access (supervisor or user) and its kind (load, store or instruction fetch). The requester also supplies the page number of the root table and the size of physical memory.

A walk either ends in a leaf entry whose permissions allow the access, or it ends in a fault. When the leaf sits above the last level it maps a superpage, and the walker builds the page number of the 4 KiB page inside it from the low virtual page number bits. Before it reports, the walker marks the leaf as referenced, and also as dirty when the access is a store. It writes the entry back only when that changes the entry.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `mem_req_o` is 0 and `done_o` is 0. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 until the walk ends. Every accepted request produces exactly one single-cycle `done_o` pulse, and `req_ready_o` returns to 1 in the cycle after that pulse.
- R2: If bits 63:38 of the virtual address are not all equal, the walk faults without any memory access. The fault is reported two cycles after acceptance.
- R3: The first table base is `root_ppn_i` shifted left by 12. At each level the entry address is the table base plus 8 times a 9-bit index. The index is taken from VA bits 38:30 at the top level, then bits 29:21, then bits 20:12.
- R4: In an entry, bits 2:0 hold the type, bits 4:3 the permission field, bit 6 the referenced flag, bit 7 the dirty flag, and bits 10 and up the page number. Type 0 faults. Type 1 points to a next table whose base is the page number shifted left by 12. Types 2 to 7 are leaves.
- R5: Type 2 is a user-only leaf. User read is always granted, permission bit 0 grants user write, and permission bit 1 grants user execute. Every supervisor access faults.
- R6: Type 3 is a supervisor-only leaf. Supervisor read is always granted, permission bit 0 grants supervisor write, and permission bit 1 grants supervisor execute. Every user access faults.
- R7: Types 4 to 7 let both modes read. Permission bit 0 grants user write and permission bit 1 grants user execute. Type bit 0 grants supervisor write and type bit 1 grants supervisor execute.
- R8: When a leaf grants the access, the walker writes the entry back to the same address before `done_o`. The written value has bit 6 set, and bit 7 also set on a store. No write is issued when the entry would not change.
- R9: A leaf found at level L, where the last level is 0, yields a page number equal to its own page number ORed with the lowest 9*L bits of the virtual page number. `pbase_o` is that page number shifted left by 12.
- R10: The walk faults if an entry address, or the final page base, is greater than or equal to `mem_size_i`. When the entry address is out of range, the walker does not read it.
- R11: A type-1 entry read at the last level faults.
- R12: While `mem_req_o` is 1 and `mem_ack_i` is 0, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged.
- R13: `fault_o` is 1 only while `done_o` is 1. While `fault_o` is 1, `pbase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_va_i | input | XLEN | Virtual address |
| req_priv_s_i | input | 1 | 1 = supervisor access, 0 = user access |
| req_store_i | input | 1 | Access is a store |
| req_fetch_i | input | 1 | Access is an instruction fetch (checked only when not a store) |
| root_ppn_i | input | PA_W-12 | Page number of the root table |
| mem_size_i | input | PA_W | Bytes of physical memory; addresses at or above this value are illegal |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | PA_W | Byte address of the entry |
| mem_wdata_o | output | 64 | Entry value to write |
| mem_ack_i | input | 1 | Access complete; read data valid with it |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Walk finished, one-cycle pulse |
| fault_o | output | 1 | Walk finished with a fault |
| pbase_o | output | PA_W | Physical page base, valid with done_o when there is no fault |

## Verification
The walker is driven with a fixed three-level table. Each case is set apart by the level at which the walk stops, the leaf type and the privilege and kind of the access, so that every entry in the permission decode is reached from both modes. The cases include leaves whose flags are clear and leaves whose flags are already set, which shows whether the write-back is skipped when nothing changes. Gigapage and megapage leaves show whether the low virtual page number bits are ORed in. Other cases show whether the sign-extension check, the memory limit at both the entry and the final page, and the last-level pointer rule each end the walk at the right access count and address. The whole set is run at two memory latencies, to show that the walker waits on the acknowledge and does not count cycles.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int PG_W          = 12;
  localparam int IDX_W         = 9;
  localparam int PTE_W         = 64;
  localparam int PTE_PPN_LSB   = 10;
  localparam int PTE_REF_BIT   = 6;
  localparam int PTE_DIRTY_BIT = 7;

  localparam logic [2:0] TY_INVALID = 3'd0;
  localparam logic [2:0] TY_NEXT    = 3'd1;
  localparam logic [2:0] TY_USER    = 3'd2;
  localparam logic [2:0] TY_SUPER   = 3'd3;

  typedef struct packed {
    logic priv_s;
    logic is_store;
    logic is_fetch;
  } acc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } walk_st_t;
endpackage

// File: rtl/ptw_perm.sv
`timescale 1ns/1ps
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [2:0] typ_i,
  input  logic [1:0] perm_i,
  input  acc_t       acc_i,
  output logic       grant_o
);
  logic u_r, u_w, u_x, s_r, s_w, s_x;

  always_comb begin
    u_r = 1'b0; u_w = 1'b0; u_x = 1'b0;
    s_r = 1'b0; s_w = 1'b0; s_x = 1'b0;
    case (typ_i)
      TY_INVALID, TY_NEXT: ;
      TY_USER: begin
        u_r = 1'b1; u_w = perm_i[0]; u_x = perm_i[1];
      end
      TY_SUPER: begin
        s_r = 1'b1; s_w = perm_i[0]; s_x = perm_i[1];
      end
      default: begin
        // shared leaf: perm field is user side, type low bits are supervisor side
        u_r = 1'b1; u_w = perm_i[0]; u_x = perm_i[1];
        s_r = 1'b1; s_w = typ_i[0];  s_x = typ_i[1];
      end
    endcase
  end

  always_comb begin
    if (acc_i.priv_s)
      grant_o = acc_i.is_store ? s_w : (acc_i.is_fetch ? s_x : s_r);
    else
      grant_o = acc_i.is_store ? u_w : (acc_i.is_fetch ? u_x : u_r);
  end
endmodule

// File: rtl/ptw_addr.sv
`timescale 1ns/1ps
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LEVELS = 3,
  parameter int PA_W   = 40,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PPN_W = PA_W - PG_W
) (
  input  logic [XLEN-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [PPN_W-1:0] tbl_ppn_i,
  input  logic [PPN_W-1:0] leaf_ppn_i,
  output logic             canon_o,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [PA_W-1:0]  leaf_pa_o
);
  localparam int VPN_W  = LEVELS * IDX_W;
  localparam int VA_W   = PG_W + VPN_W;
  localparam int ENT_SH = PG_W - IDX_W;

  logic [XLEN-VA_W:0] va_hi;
  logic [IDX_W-1:0]   idx;
  logic [PPN_W-1:0]   vpn_ext;
  logic [PPN_W-1:0]   low_mask;

  assign va_hi   = va_i[XLEN-1:VA_W-1];
  assign canon_o = (&va_hi) | ~(|va_hi);

  always_comb begin
    int sh;
    sh  = PG_W + int'(lvl_i) * IDX_W;
    idx = va_i[sh +: IDX_W];
  end

  assign pte_addr_o = {tbl_ppn_i, idx, {ENT_SH{1'b0}}};

  always_comb begin
    vpn_ext = '0;
    vpn_ext[VPN_W-1:0] = va_i[VA_W-1:PG_W];
    low_mask = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (l < int'(lvl_i)) low_mask[l*IDX_W +: IDX_W] = '1;
    end
  end

  assign leaf_pa_o = {leaf_ppn_i | (vpn_ext & low_mask), {PG_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import ptw_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LEVELS = 3,
  parameter int PA_W   = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [XLEN-1:0]      req_va_i,
  input  logic                 req_priv_s_i,
  input  logic                 req_store_i,
  input  logic                 req_fetch_i,
  input  logic [PA_W-PG_W-1:0] root_ppn_i,
  input  logic [PA_W-1:0]      mem_size_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [PA_W-1:0]      mem_addr_o,
  output logic [PTE_W-1:0]     mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [PTE_W-1:0]     mem_rdata_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [PA_W-1:0]      pbase_o
);
  localparam int PPN_W = PA_W - PG_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  walk_st_t         st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] tbl_q;
  logic [XLEN-1:0]  va_q;
  acc_t             acc_q;
  logic [PA_W-1:0]  ent_addr_q;
  logic [PA_W-1:0]  pbase_q;
  logic [PTE_W-1:0] pte_q;
  logic             fault_q;

  logic [2:0]       r_typ;
  logic [1:0]       r_perm;
  logic [PPN_W-1:0] r_ppn;
  logic [PTE_W-1:0] r_upd;
  logic             grant;
  logic             canon;
  logic [PA_W-1:0]  ent_addr;
  logic [PA_W-1:0]  leaf_pa;

  assign r_typ  = mem_rdata_i[2:0];
  assign r_perm = mem_rdata_i[4:3];
  assign r_ppn  = mem_rdata_i[PTE_PPN_LSB +: PPN_W];

  always_comb begin
    r_upd = mem_rdata_i;
    r_upd[PTE_REF_BIT] = 1'b1;
    if (acc_q.is_store) r_upd[PTE_DIRTY_BIT] = 1'b1;
  end

  ptw_perm u_perm (
    .typ_i   (r_typ),
    .perm_i  (r_perm),
    .acc_i   (acc_q),
    .grant_o (grant)
  );

  ptw_addr #(
    .XLEN   (XLEN),
    .LEVELS (LEVELS),
    .PA_W   (PA_W)
  ) u_addr (
    .va_i       (va_q),
    .lvl_i      (lvl_q),
    .tbl_ppn_i  (tbl_q),
    .leaf_ppn_i (r_ppn),
    .canon_o    (canon),
    .pte_addr_o (ent_addr),
    .leaf_pa_o  (leaf_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      lvl_q      <= '0;
      tbl_q      <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      ent_addr_q <= '0;
      pbase_q    <= '0;
      pte_q      <= '0;
      fault_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q           <= req_va_i;
            acc_q.priv_s   <= req_priv_s_i;
            acc_q.is_store <= req_store_i;
            acc_q.is_fetch <= req_fetch_i;
            tbl_q          <= root_ppn_i;
            lvl_q          <= LVL_W'(LEVELS - 1);
            fault_q        <= 1'b0;
            pbase_q        <= '0;
            st_q           <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!canon || ent_addr >= mem_size_i) begin
            fault_q <= 1'b1;
            st_q    <= ST_DONE;
          end else begin
            ent_addr_q <= ent_addr;
            st_q       <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack_i) begin
            if (r_typ == TY_INVALID) begin
              fault_q <= 1'b1;
              st_q    <= ST_DONE;
            end else if (r_typ == TY_NEXT) begin
              if (lvl_q == '0) begin
                fault_q <= 1'b1;
                st_q    <= ST_DONE;
              end else begin
                tbl_q <= r_ppn;
                lvl_q <= lvl_q - 1'b1;
                st_q  <= ST_LOOK;
              end
            end else if (!grant) begin
              fault_q <= 1'b1;
              st_q    <= ST_DONE;
            end else begin
              pbase_q <= leaf_pa;
              fault_q <= (leaf_pa >= mem_size_i);
              pte_q   <= r_upd;
              st_q    <= (r_upd != mem_rdata_i) ? ST_WRITE : ST_DONE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack_i) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we_o    = (st_q == ST_WRITE);
  assign mem_addr_o  = ent_addr_q;
  assign mem_wdata_o = pte_q;
  assign done_o      = (st_q == ST_DONE);
  assign fault_o     = done_o && fault_q;
  assign pbase_o     = (done_o && !fault_q) ? pbase_q : '0;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int XLEN   = 64,
  parameter int LEVELS = 3,
  parameter int PA_W   = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [XLEN-1:0] req_va_i,
  input logic [PA_W-1:0] mem_size_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic [63:0]     mem_wdata_o,
  input logic            mem_ack_i,
  input logic            done_o,
  input logic            fault_o,
  input logic [PA_W-1:0] pbase_o
);
  localparam int VA_W = 12 + LEVELS * 9;

  logic [XLEN-VA_W:0] va_hi;
  logic               va_ok;
  assign va_hi = req_va_i[XLEN-1:VA_W-1];
  assign va_ok = (&va_hi) | ~(|va_hi);

  assert_idle_no_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  assert_noncanon_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !va_ok) |-> ##2 (done_o && fault_o));

  assert_entry_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  assert_wb_sets_ref_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[6]);

  assert_pbase_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (pbase_o < mem_size_i) && (pbase_o[11:0] == 12'h000));

  assert_port_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_we_o) &&
                                  $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_fault_with_done_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && (pbase_o == '0));
endmodule

bind pt_walker pt_walker_chk #(
  .XLEN   (XLEN),
  .LEVELS (LEVELS),
  .PA_W   (PA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_va_i    (req_va_i),
  .mem_size_i  (mem_size_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .pbase_o     (pbase_o)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  localparam int XLEN = 64;
  localparam int PA_W = 40;
  localparam int NV   = 21;

  typedef struct packed {
    logic [63:0]     va;
    logic            s;
    logic            st;
    logic            fx;
    logic            flt;
    logic [PA_W-1:0] pb;
    logic [3:0]      nrd;
    logic            nwr;
    logic [63:0]     wd;
    logic [PA_W-1:0] la;
  } vec_t;

  // fields: va, sup, store, fetch, fault, pbase, reads, write, wdata, last address
  localparam vec_t VEC [NV] = '{
    '{64'h123,               1'b0,1'b0,1'b0, 1'b0, 40'h300000,   4'd3,1'b1,64'hC0042, 40'h102000},
    '{64'h123,               1'b0,1'b1,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102000},
    '{64'h123,               1'b1,1'b0,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102000},
    '{64'h1000,              1'b1,1'b0,1'b1, 1'b0, 40'h301000,   4'd3,1'b0,64'h0,     40'h102008},
    '{64'h1000,              1'b1,1'b1,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102008},
    '{64'h1000,              1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102008},
    '{64'h2000,              1'b1,1'b1,1'b0, 1'b0, 40'h302000,   4'd3,1'b0,64'h0,     40'h102010},
    '{64'h2000,              1'b0,1'b1,1'b0, 1'b0, 40'h302000,   4'd3,1'b0,64'h0,     40'h102010},
    '{64'h2000,              1'b1,1'b0,1'b1, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102010},
    '{64'h6000,              1'b0,1'b0,1'b1, 1'b0, 40'h306000,   4'd3,1'b0,64'h0,     40'h102030},
    '{64'h6000,              1'b1,1'b1,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102030},
    '{64'h3000,              1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102018},
    '{64'h4000,              1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd3,1'b0,64'h0,     40'h102020},
    '{64'h205018,            1'b0,1'b1,1'b0, 1'b0, 40'h205000,   4'd2,1'b1,64'h800CA, 40'h101008},
    '{64'h52345ABC,          1'b0,1'b0,1'b0, 1'b0, 40'h12345000, 4'd1,1'b0,64'h0,     40'h100008},
    '{64'hC0042000,          1'b1,1'b0,1'b0, 1'b0, 40'h20042000, 4'd1,1'b0,64'h0,     40'h100018},
    '{64'h100000000,         1'b1,1'b0,1'b0, 1'b1, 40'h0,        4'd1,1'b0,64'h0,     40'h100020},
    '{64'h140000000,         1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd1,1'b0,64'h0,     40'h100028},
    '{64'h80000000,          1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd1,1'b0,64'h0,     40'h100010},
    '{64'h8000000000,        1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd0,1'b0,64'h0,     40'h0},
    '{64'hFFFFFFC000000000,  1'b0,1'b0,1'b0, 1'b1, 40'h0,        4'd1,1'b0,64'h0,     40'h100800}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            req_valid_i;
  logic            req_ready_o;
  logic [XLEN-1:0] req_va_i;
  logic            req_priv_s_i;
  logic            req_store_i;
  logic            req_fetch_i;
  logic [PA_W-13:0] root_ppn_i;
  logic [PA_W-1:0] mem_size_i;
  logic            mem_req_o;
  logic            mem_we_o;
  logic [PA_W-1:0] mem_addr_o;
  logic [63:0]     mem_wdata_o;
  logic            mem_ack_i;
  logic [63:0]     mem_rdata_i;
  logic            done_o;
  logic            fault_o;
  logic [PA_W-1:0] pbase_o;

  pt_walker #(.XLEN(XLEN), .LEVELS(3), .PA_W(PA_W)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_va_i, .req_priv_s_i,
    .req_store_i, .req_fetch_i, .root_ppn_i, .mem_size_i, .mem_req_o,
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .done_o, .fault_o, .pbase_o
  );

  always #2 clk_i = ~clk_i;

  logic [63:0] mem [logic [PA_W-1:0]];
  int          lat = 0;
  int          nrd = 0;
  int          nwr = 0;
  logic [63:0] last_wd = '0;
  logic [PA_W-1:0] last_addr = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  string       tags [NV];

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic init_mem();
    mem.delete();
    mem[40'h100000] = 64'h40401;      // root 0: next table ppn 0x101
    mem[40'h100008] = 64'hDF;         // root 1: gigapage type 7, ppn 0, R/D set
    mem[40'h100018] = 64'h80000C4;    // root 3: gigapage type 4, ppn 0x20000
    mem[40'h100020] = 64'h200000C3;   // root 4: type 3 ppn 0x80000, beyond memory
    mem[40'h100028] = 64'h3FFFFC01;   // root 5: next table beyond memory
    mem[40'h101000] = 64'h40801;      // L1 0: next table ppn 0x102
    mem[40'h101008] = 64'h8000A;      // L1 1: megapage type 2 perm 1 ppn 0x200
    mem[40'h102000] = 64'hC0002;      // type 2 perm 0
    mem[40'h102008] = 64'hC0453;      // type 3 perm 2, R set
    mem[40'h102010] = 64'hC08CD;      // type 5 perm 1, R/D set
    mem[40'h102018] = 64'h1C01;       // pointer at last level
    mem[40'h102020] = 64'h0;          // invalid
    mem[40'h102030] = 64'hC18D6;      // type 6 perm 2, R/D set
  endtask

  // memory responder
  initial begin
    mem_ack_i   = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(posedge clk_i);
      mem_ack_i <= 1'b0;
      if (mem_req_o && !mem_ack_i) begin
        logic [PA_W-1:0] a;
        logic            w;
        logic [63:0]     d;
        a = mem_addr_o; w = mem_we_o; d = mem_wdata_o;
        repeat (lat) @(posedge clk_i);
        if (w) begin
          nwr++;
          last_wd = d;
        end else begin
          nrd++;
          mem_rdata_i <= mem.exists(a) ? mem[a] : 64'h0;
        end
        last_addr = a;
        mem_ack_i <= 1'b1;
      end
    end
  end

  task automatic start_req(input vec_t v);
    @(negedge clk_i);
    req_va_i     = v.va;
    req_priv_s_i = v.s;
    req_store_i  = v.st;
    req_fetch_i  = v.fx;
    req_valid_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done_o; i++) @(negedge clk_i);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int rd0, wr0;
    init_mem();
    rd0 = nrd; wr0 = nwr;
    start_req(v);
    chk("R1", "ready while busy", {63'b0, req_ready_o}, 64'd0);
    wait_done();
    chk(tag, "done", {63'b0, done_o}, 64'd1);
    chk(tag, "fault", {63'b0, fault_o}, {63'b0, v.flt});
    chk(tag, "pbase", {24'b0, pbase_o}, {24'b0, v.pb});
    chk(tag, "reads", 64'(nrd - rd0), {60'b0, v.nrd});
    chk(tag, "writes", 64'(nwr - wr0), {63'b0, v.nwr});
    if (v.nwr) chk(tag, "write data", last_wd, v.wd);
    if (v.nrd != 0) chk(tag, "last address", {24'b0, last_addr}, {24'b0, v.la});
    @(negedge clk_i);
    chk("R1", "single done pulse", {62'b0, done_o, req_ready_o}, 64'd1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tags = '{"R8","R5","R5","R6","R6","R6","R7","R7","R7","R7","R7",
             "R11","R4","R9","R9","R9","R10","R10","R4","R2","R3"};
    rst_ni       = 1'b0;
    req_valid_i  = 1'b0;
    req_va_i     = '0;
    req_priv_s_i = 1'b0;
    req_store_i  = 1'b0;
    req_fetch_i  = 1'b0;
    root_ppn_i   = 28'h100;
    mem_size_i   = 40'h40000000;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset ready", {63'b0, req_ready_o}, 64'd1);
    chk("R1", "reset mem_req", {63'b0, mem_req_o}, 64'd0);
    chk("R1", "reset done", {63'b0, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int p = 0; p < 2; p++) begin
      lat = p * 2;
      for (int i = 0; i < NV; i++) run_vec(VEC[i], tags[i]);
    end

    // R12: request held steady during a slow access
    begin
      logic [PA_W-1:0] a0;
      lat = 3;
      init_mem();
      start_req(VEC[0]);
      for (int i = 0; i < 20 && !mem_req_o; i++) @(negedge clk_i);
      a0 = mem_addr_o;
      @(negedge clk_i);
      @(negedge clk_i);
      chk("R12", "req held", {63'b0, mem_req_o}, 64'd1);
      chk("R12", "addr held", {24'b0, mem_addr_o}, {24'b0, a0});
      wait_done();
      chk("R12", "slow walk result", {24'b0, pbase_o}, 64'h300000);
      @(negedge clk_i);
    end

    // R10: root table itself beyond memory, no read issued
    begin
      int rd0;
      lat = 0;
      mem_size_i = 40'h100000;
      init_mem();
      rd0 = nrd;
      start_req(VEC[14]);
      wait_done();
      chk("R10", "root beyond memory fault", {63'b0, fault_o}, 64'd1);
      chk("R10", "root beyond memory reads", 64'(nrd - rd0), 64'd0);
      @(negedge clk_i);
      mem_size_i = 40'h40000000;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule